// File: doc/BRIEF.md
# Center-Aligned Complementary PWM Pair with Dead-Time

This block drives one complementary pair of PWM outputs from a symmetric up/down timebase. The counter climbs from zero to a programmable modulus and falls back to zero, so every pulse is centred on the zero point of the count. A compare value sets where the primary output switches. The secondary output is the inverse of the primary.

A programmable dead-time holds back each rising edge of each output. Falling edges pass through without delay. The two outputs therefore never overlap, and the pulse pair stays symmetric about the period centre. Each output has its own polarity inversion. A trigger output marks the cycles in which the count sits at zero.

Modulus and compare values take effect only at the zero point of the count, so a running period is never disturbed. An integrator connects static configuration inputs and takes the two gate-drive outputs and the trigger.

Top module: `cpwm_pair`

## Requirements
- R1: After reset, `cnt_o` counts 0, 1, …, M, M−1, …, 1, 0, 1, … with M the active modulus. The period is 2·M clock cycles, so M = 2000 at 80 MHz gives 50 µs. With M = 0 the count stays at 0.
- R2: `init_trig_o` is 1 exactly in the cycles in which `cnt_o` is 0.
- R3: The raw primary level is 1 while `cnt_o` < the active compare value C. The raw secondary level is its inverse. With `dt_en_i` = 0, each output's active level equals its raw level one cycle earlier.
- R4: With `dt_en_i` = 1, an output becomes active one cycle after its raw level has been 1 for `dt_i`+1 consecutive cycles, which is `dt_i` cycles later than with dead-time off. It becomes inactive one cycle after its raw level drops.
- R5: A raw pulse shorter than `dt_i`+1 cycles produces no active output at all.
- R6: The active levels of the two outputs are never 1 in the same cycle.
- R7: `pwm_o[i]` equals the active level of output i XOR `pol_i[i]`. Bit 0 is the primary output and bit 1 is the secondary. With `pol_i[i]` = 0 the output is active-high.
- R8: C = 0 holds the primary inactive and the secondary active for the whole period. C > M holds the primary active for the whole period, apart from the dead-time delay after reset. Neither case produces a glitch.
- R9: `mod_i` and `cmp_i` are sampled only in a cycle where the count is 0. A change in the middle of a period takes effect from the next zero point.
- R10: While `rst_ni` is low, `cnt_o` is 0, the direction is up, and both outputs sit at their inactive level (`pwm_o` = `pol_i`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_i | input | CNT_W | Modulus (turn-around count) |
| cmp_i | input | CNT_W | Compare value for the primary output |
| dt_i | input | DT_W | Dead-time in clock cycles |
| dt_en_i | input | 1 | Dead-time insertion enable |
| pol_i | input | 2 | Per-output polarity inversion |
| cnt_o | output | CNT_W | Current timebase count |
| init_trig_o | output | 1 | High while the count is zero |
| pwm_o | output | 2 | Complementary outputs, bit 0 primary |

## Verification
The temporal properties assume that `dt_i`, `dt_en_i` and `pol_i` hold steady while the counter runs, and that `mod_i` and `cmp_i` change only where the shadow registers absorb the change. The bench keeps to this. It applies each dead-time, enable and polarity setting under reset and leaves it fixed for the whole run. It changes the compare value only once, in the middle of a period, to show that the change is deferred to the next zero point. The modulus stays constant within a run, so the expected count follows arithmetically from the cycle index.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} cnt_dir_e;
  localparam int unsigned NUM_OUT = 2;
endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
  import cpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] mod_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] mod_act_o,
  output cnt_dir_e         dir_o,
  output logic [1:0]       raw_o
);
  logic [CNT_W-1:0] cnt_q, mod_q, cmp_q;
  logic [CNT_W-1:0] mod_eff, cmp_eff;
  cnt_dir_e         dir_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  // shadow values become live at the zero point
  assign mod_eff = at_zero ? mod_i : mod_q;
  assign cmp_eff = at_zero ? cmp_i : cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q <= '0;
      cmp_q <= '0;
    end else if (at_zero) begin
      mod_q <= mod_i;
      cmp_q <= cmp_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (at_zero) begin
      dir_q <= DIR_UP;
      cnt_q <= (mod_eff != '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : '0;
    end else if (dir_q == DIR_UP) begin
      if (cnt_q >= mod_eff) begin
        dir_q <= DIR_DN;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign raw_o[0]  = (cnt_q < cmp_eff);
  assign raw_o[1]  = ~raw_o[0];
  assign cnt_o     = cnt_q;
  assign mod_act_o = mod_q;
  assign dir_o     = dir_q;
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [DT_W-1:0] dt_i,
  input  logic            raw_i,
  output logic            act_o
);
  logic [DT_W-1:0] hi_q;
  logic            act_q;

  // hi_q counts cycles of raw high; stops at dt_i so it never wraps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      act_q <= 1'b0;
    end else if (!en_i) begin
      hi_q  <= '0;
      act_q <= raw_i;
    end else if (!raw_i) begin
      hi_q  <= '0;
      act_q <= 1'b0;
    end else if (!act_q) begin
      if (hi_q >= dt_i) act_q <= 1'b1;
      else              hi_q  <= hi_q + 1'b1;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair
  import cpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] mod_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [DT_W-1:0]  dt_i,
  input  logic             dt_en_i,
  input  logic [1:0]       pol_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             init_trig_o,
  output logic [1:0]       pwm_o
);
  logic [NUM_OUT-1:0] raw;
  logic [NUM_OUT-1:0] act;
  logic [CNT_W-1:0]   mod_act;
  cnt_dir_e           dir;

  cpwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mod_i     (mod_i),
    .cmp_i     (cmp_i),
    .cnt_o     (cnt_o),
    .mod_act_o (mod_act),
    .dir_o     (dir),
    .raw_o     (raw)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    cpwm_deadband #(.DT_W(DT_W)) u_db (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (dt_en_i),
      .dt_i   (dt_i),
      .raw_i  (raw[i]),
      .act_o  (act[i])
    );
    assign pwm_o[i] = act[i] ^ pol_i[i];
  end

  assign init_trig_o = (cnt_o == '0);
endmodule

// File: rtl/cpwm_pair_chk.sv
module cpwm_pair_chk
  import cpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       pol_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             init_trig_o,
  input logic [1:0]       pwm_o,
  input logic [1:0]       raw,
  input logic [1:0]       act,
  input logic [CNT_W-1:0] mod_act,
  input cnt_dir_e         dir
);
  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cnt_o == $past(cnt_o) + 1'b1) || (cnt_o + 1'b1 == $past(cnt_o)) ||
              (cnt_o == '0 && $past(cnt_o) == '0)));
  // R2
  trig_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_trig_o |=> (cnt_o <= 1));
  // R6
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act[0] && act[1]));
  // R4
  fall_prompt_p_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raw[0] |=> !act[0]);
  // R4
  fall_prompt_s_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raw[1] |=> !act[1]);
  // R4
  rise_needs_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act[0]) |-> $past(raw[0]));
  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != '0) |=> $stable(mod_act));
  // R10
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_idle_chk: assert (pwm_o == pol_i && cnt_o == '0 && dir == DIR_UP);
    end
  end
endmodule

bind cpwm_pair cpwm_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pol_i       (pol_i),
  .cnt_o       (cnt_o),
  .init_trig_o (init_trig_o),
  .pwm_o       (pwm_o),
  .raw         (raw),
  .act         (act),
  .mod_act     (mod_act),
  .dir         (dir)
);

// File: tb/sim_cpwm_pair.sv
`timescale 1ns/1ps
module sim_cpwm_pair;
  localparam real CLK_PERIOD = 12.5;
  localparam int  CNT_W = 16;
  localparam int  DT_W  = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CNT_W-1:0] mod_i = '0;
  logic [CNT_W-1:0] cmp_i = '0;
  logic [DT_W-1:0]  dt_i = '0;
  logic             dt_en_i = 1'b0;
  logic [1:0]       pol_i = '0;
  logic [CNT_W-1:0] cnt_o;
  logic             init_trig_o;
  logic [1:0]       pwm_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2.0) clk_i = ~clk_i;

  cpwm_pair #(.CNT_W(CNT_W), .DT_W(DT_W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .mod_i(mod_i), .cmp_i(cmp_i),
    .dt_i(dt_i), .dt_en_i(dt_en_i), .pol_i(pol_i),
    .cnt_o(cnt_o), .init_trig_o(init_trig_o), .pwm_o(pwm_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one configuration: reset, then N cycles checked against an arithmetic model
  task automatic run(input int m, input int c, input int dt, input bit en,
                     input int pol, input int n, input int chg_k, input int chg_c);
    int cmp_a = c;
    int run_len[2] = '{0, 0};
    bit exp_act[2] = '{1'b0, 1'b0};
    string tag;
    tag = en ? "R4 R5" : "R3";
    if (c == 0 || c > m) tag = {tag, " R8"};
    if (pol != 0)        tag = {tag, " R7"};
    if (chg_k >= 0)      tag = {tag, " R9"};
    rst_ni  = 1'b0;
    mod_i   = CNT_W'(m);
    cmp_i   = CNT_W'(c);
    dt_i    = DT_W'(dt);
    dt_en_i = en;
    pol_i   = 2'(pol);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    chk(int'(cnt_o) == 0, "R10 reset count", int'(cnt_o), 0);
    chk(int'(pwm_o) == pol, "R10 reset outputs", int'(pwm_o), pol);
    rst_ni = 1'b1;
    for (int k = 0; k < n; k++) begin
      int p, cm, pe;
      bit raw_e;
      p  = (m == 0) ? 0 : k % (2*m);
      cm = (p <= m) ? p : 2*m - p;
      chk(int'(cnt_o) == cm, "R1 count", int'(cnt_o), cm);
      chk(init_trig_o == (cm == 0), "R2 trigger", int'(init_trig_o), int'(cm == 0));
      pe = int'(exp_act[0] ^ pol[0]) | (int'(exp_act[1] ^ pol[1]) << 1);
      chk(int'(pwm_o) == pe, tag, int'(pwm_o), pe);
      chk(!((pwm_o[0] ^ pol_i[0]) && (pwm_o[1] ^ pol_i[1])), "R6 overlap",
          int'(pwm_o ^ pol_i), 0);
      if (k == chg_k) cmp_i = CNT_W'(chg_c);
      if (cm == 0) cmp_a = int'(cmp_i);
      raw_e = (cm < cmp_a);
      run_len[0] = raw_e  ? run_len[0] + 1 : 0;
      run_len[1] = !raw_e ? run_len[1] + 1 : 0;
      exp_act[0] = en ? (run_len[0] >= dt + 1) : raw_e;
      exp_act[1] = en ? (run_len[1] >= dt + 1) : !raw_e;
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000.0);
    errors++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // near-exhaustive sweep of a small configuration space
    for (int m = 1; m <= 5; m++)
      for (int c = 0; c <= m + 1; c++)
        for (int dt = 0; dt <= 3; dt++)
          for (int en = 0; en <= 1; en++)
            run(m, c, dt, en[0], (m + c + dt + en) % 4, 6*m + dt + 4, -1, 0);
    // degenerate modulus: count parked at zero
    run(0, 1, 0, 1'b0, 0, 8, -1, 0);
    // mid-period compare change, deferred to the next zero point
    run(8, 3, 1, 1'b1, 0, 60, 5, 6);
    run(8, 6, 0, 1'b0, 2, 60, 20, 0);
    // full-scale case: 50 us period at 80 MHz, 100-cycle dead-time
    run(2000, 1000, 100, 1'b1, 0, 8200, -1, 0);
    run(2000, 1000, 100, 1'b0, 1, 4100, -1, 0);
    finish_run();
  end
endmodule